// File: doc/BRIEF.md
# Segment-Then-Page Address Translation Walker

This block turns a 24-bit virtual address into a 24-bit physical address in two steps. The top 4 bits pick one of 16 segment descriptors held in on-chip registers. Each descriptor has a valid flag, a base pointer to a page table in memory, and a table length. The next 8 bits are a virtual page number. That number is checked against the descriptor's length, and then the walker reads one page-table word from memory. The low 12 bits of that word give the physical page, which is placed above the unchanged 12-bit offset.

A processor-side request channel and a response channel both use valid/ready. A request is taken only when `req_ready` is high. This happens only while the walker is idle, so at most one translation is in flight. The response stays valid with stable contents until `rsp_ready` accepts it. While a response waits, no new request is accepted. The memory side issues one read at a time: `mem_req_valid`/`mem_req_ready` for the address, then a one-cycle `mem_rsp_valid` pulse with the word. A privileged write port loads or clears descriptors. A fault returns a code and skips the memory read.

Top module: `xlat_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. All 16 segment descriptors are invalid.
- R2: The virtual address fields are: segment = bits 23:20, page number = bits 19:12, offset = bits 11:0.
- R3: A request to an invalid segment responds with `rsp_fault`=1 and `rsp_code`=1. It makes no memory request.
- R4: A page number greater than or equal to the segment's length (a 9-bit value, 0..256) responds with `rsp_fault`=1 and `rsp_code`=2. It makes no memory request. For example, with length 0x14, pages 0x00..0x13 pass and 0x14 and above fault.
- R5: A walk that passes the checks issues exactly one memory read. Its address is the segment pointer plus the page number, modulo 2^16. The address is held stable while `mem_req_valid` is high and `mem_req_ready` is low.
- R6: A successful response has `rsp_fault`=0, `rsp_code`=0, and `rsp_paddr` = {low 12 bits of the returned word, virtual offset}.
- R7: `req_ready` is high only while idle. After a request is accepted, no further request is taken until the response has been consumed.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response stays valid and its address, fault flag and code do not change.
- R9: A cycle with `tbl_we`=1 writes the valid flag, pointer and length into descriptor `tbl_idx`, for use by requests accepted afterwards. Writing valid=0 makes that segment fault as in R3.
- R10: A faulting response reports `rsp_paddr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 24 | Virtual address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 24 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation failed |
| rsp_code | output | 2 | 0 ok, 1 invalid segment, 2 page beyond length |
| mem_req_valid | output | 1 | Page-table read request present |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 16 | Word address of the page-table entry |
| mem_rsp_valid | input | 1 | One-cycle pulse with read data |
| mem_rsp_data | input | 16 | Page-table entry word |
| tbl_we | input | 1 | Descriptor write strobe |
| tbl_idx | input | 4 | Descriptor to write |
| tbl_valid | input | 1 | Valid flag to store |
| tbl_ptr | input | 16 | Page-table base word address to store |
| tbl_len | input | 9 | Page-table length in entries to store |

## Verification
Some properties are checked on every cycle. Response and memory-address stability under back-pressure are covered. So is a zero address on every fault, and a fault code that always agrees with the fault flag. A failed check must go straight to a response with no memory request. An accepted request must drop `req_ready`. A descriptor write must show up in the stored entry on the next cycle. Other behaviour can only be shown by the bench's scenarios against its own model. These are the translated address values and the exact read address with 16-bit wrap. They also cover the length boundary at 0x13/0x14 and at 0 and 256, the count of memory reads per walk, and segment invalidation.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_MREQ,
    ST_MWAIT,
    ST_RESP
  } walk_st_e;

  typedef enum logic [1:0] {
    FC_NONE  = 2'd0,
    FC_NOSEG = 2'd1,
    FC_RANGE = 2'd2
  } fault_e;
endpackage

// File: rtl/xlat_segtab.sv
module xlat_segtab #(
  parameter int SEG_W = 4,
  parameter int PTR_W = 16,
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [LEN_W-1:0] wr_len,
  input  logic [SEG_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [LEN_W-1:0] rd_len
);
  localparam int NSEG = 1 << SEG_W;

  logic [NSEG-1:0] vld_vec;
  logic [PTR_W-1:0] ptr_arr [NSEG];
  logic [LEN_W-1:0] len_arr [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic             v_q;
    logic [PTR_W-1:0] p_q;
    logic [LEN_W-1:0] l_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        p_q <= '0;
        l_q <= '0;
      end else if (wr_en && (wr_idx == SEG_W'(g))) begin
        v_q <= wr_valid;
        p_q <= wr_ptr;
        l_q <= wr_len;
      end
    end
    assign vld_vec[g] = v_q;
    assign ptr_arr[g] = p_q;
    assign len_arr[g] = l_q;
  end

  assign rd_valid = vld_vec[rd_idx];
  assign rd_ptr   = ptr_arr[rd_idx];
  assign rd_len   = len_arr[rd_idx];

  // R9
  tbl_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_vec[$past(wr_idx)] == $past(wr_valid)) &&
              (len_arr[$past(wr_idx)] == $past(wr_len)));
endmodule

// File: rtl/xlat_check.sv
module xlat_check
  import xlat_pkg::*;
#(
  parameter int VPN_W = 8,
  parameter int PTR_W = 16,
  parameter int LEN_W = VPN_W + 1
) (
  input  logic             seg_valid,
  input  logic [PTR_W-1:0] seg_ptr,
  input  logic [LEN_W-1:0] seg_len,
  input  logic [VPN_W-1:0] vpn,
  output fault_e           code,
  output logic [PTR_W-1:0] entry_addr
);
  logic beyond;

  always_comb begin
    beyond = ({1'b0, vpn} >= seg_len);
    if (!seg_valid)  code = FC_NOSEG;
    else if (beyond) code = FC_RANGE;
    else             code = FC_NONE;
    entry_addr = seg_ptr + PTR_W'(vpn);
  end
endmodule

// File: rtl/xlat_fsm.sv
module xlat_fsm
  import xlat_pkg::*;
#(
  parameter int VA_W  = 24,
  parameter int OFF_W = 12,
  parameter int PTR_W = 16,
  parameter int PPN_W = 12,
  parameter int MDW   = 16,
  parameter int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic [VA_W-1:0]  va_q,
  input  fault_e           chk_code,
  input  logic [PTR_W-1:0] chk_addr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PTR_W-1:0] mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [MDW-1:0]   mem_rsp_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output fault_e           rsp_code
);
  walk_st_e         st_q;
  logic [PTR_W-1:0] maddr_q;
  logic [PA_W-1:0]  paddr_q;
  logic             fault_q;
  fault_e           code_q;
  logic             unused_hi;

  assign unused_hi = ^mem_rsp_data[MDW-1:PPN_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      maddr_q <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      code_q  <= FC_NONE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          va_q <= req_vaddr;
          st_q <= ST_CHECK;
        end
        ST_CHECK: if (chk_code != FC_NONE) begin
          code_q  <= chk_code;
          fault_q <= 1'b1;
          paddr_q <= '0;
          st_q    <= ST_RESP;
        end else begin
          maddr_q <= chk_addr;
          st_q    <= ST_MREQ;
        end
        ST_MREQ: if (mem_req_ready) st_q <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          paddr_q <= {mem_rsp_data[PPN_W-1:0], va_q[OFF_W-1:0]};
          fault_q <= 1'b0;
          code_q  <= FC_NONE;
          st_q    <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_MREQ);
  assign mem_req_addr  = maddr_q;
  assign rsp_valid     = (st_q == ST_RESP);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign rsp_code      = code_q;

  // R7
  accept_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) &&
                                $stable(rsp_fault) && $stable(rsp_code));
  // R5
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R3
  fault_skips_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK) && (chk_code != FC_NONE) |=> rsp_valid && !mem_req_valid);
  // R10
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);
  // R4
  code_matches_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_code != FC_NONE)));
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int VPN_W = 8,
  parameter int OFF_W = 12,
  parameter int PTR_W = 16,
  parameter int PPN_W = 12,
  parameter int MDW   = 16,
  localparam int VA_W  = SEG_W + VPN_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int LEN_W = VPN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic [1:0]       rsp_code,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PTR_W-1:0] mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [MDW-1:0]   mem_rsp_data,
  input  logic             tbl_we,
  input  logic [SEG_W-1:0] tbl_idx,
  input  logic             tbl_valid,
  input  logic [PTR_W-1:0] tbl_ptr,
  input  logic [LEN_W-1:0] tbl_len
);
  logic [VA_W-1:0]  va_q;
  logic             seg_valid;
  logic [PTR_W-1:0] seg_ptr;
  logic [LEN_W-1:0] seg_len;
  fault_e           chk_code;
  logic [PTR_W-1:0] chk_addr;
  fault_e           code_e;

  xlat_segtab #(.SEG_W(SEG_W), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_valid(tbl_valid),
    .wr_ptr(tbl_ptr), .wr_len(tbl_len),
    .rd_idx(va_q[VA_W-1 -: SEG_W]),
    .rd_valid(seg_valid), .rd_ptr(seg_ptr), .rd_len(seg_len)
  );

  xlat_check #(.VPN_W(VPN_W), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_chk (
    .seg_valid(seg_valid), .seg_ptr(seg_ptr), .seg_len(seg_len),
    .vpn(va_q[OFF_W +: VPN_W]),
    .code(chk_code), .entry_addr(chk_addr)
  );

  xlat_fsm #(.VA_W(VA_W), .OFF_W(OFF_W), .PTR_W(PTR_W), .PPN_W(PPN_W),
             .MDW(MDW), .PA_W(PA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .va_q(va_q),
    .chk_code(chk_code), .chk_addr(chk_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_code(code_e)
  );

  assign rsp_code = code_e;
endmodule

// File: tb/xlat_walker_test.sv
module xlat_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [23:0] req_vaddr = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [23:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_code;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        tbl_we = 1'b0, tbl_valid = 1'b0;
  logic [3:0]  tbl_idx = '0;
  logic [15:0] tbl_ptr = '0;
  logic [8:0]  tbl_len = '0;

  int tests = 0, fails = 0, mem_hits = 0;
  logic [15:0] last_addr = '0;
  bit done = 0;

  logic        sh_v [16];
  logic [15:0] sh_p [16];
  logic [8:0]  sh_l [16];

  always #10 clk = ~clk;

  xlat_walker uut (.*);

  function automatic logic [15:0] pte(input logic [15:0] a);
    return 16'(a * 16'h9E37 + 16'h3C5A);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // bench memory: one outstanding read, random accept and latency
  initial begin
    bit pend = 0;
    int dly = 0;
    logic [15:0] paddr_m = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pte(paddr_m);
          pend = 0;
        end else dly--;
      end
      mem_req_ready = pend ? 1'b0 : 1'($urandom % 2);
      if (mem_req_valid && mem_req_ready) begin
        pend = 1; paddr_m = mem_req_addr; last_addr = mem_req_addr;
        dly = $urandom % 3; mem_hits++;
      end
    end
  end

  task automatic load_seg(input int idx, input logic v, input logic [15:0] p, input logic [8:0] l);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 4'(idx); tbl_valid = v; tbl_ptr = p; tbl_len = l;
    @(negedge clk);
    tbl_we = 1'b0;
    sh_v[idx] = v; sh_p[idx] = p; sh_l[idx] = l;
  endtask

  task automatic xlat(input logic [23:0] va, input int hold);
    int seg = int'(va[23:20]);
    logic [7:0] vpn = va[19:12];
    logic [1:0] ecode;
    logic [23:0] epa;
    logic [15:0] eaddr;
    int hits0;
    logic [23:0] pa0;
    // R2: segment 23:20, page 19:12, offset 11:0
    eaddr = sh_p[seg] + {8'h00, vpn};
    if (!sh_v[seg]) begin ecode = 2'd1; epa = '0; end
    else if ({1'b0, vpn} >= sh_l[seg]) begin ecode = 2'd2; epa = '0; end
    else begin ecode = 2'd0; epa = {pte(eaddr)[11:0], va[11:0]}; end
    @(negedge clk);
    hits0 = mem_hits;
    req_valid = 1'b1; req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 busy after accept", 32'(req_ready), 32'd0);
    while (!rsp_valid) @(negedge clk);
    check(ecode == 0 ? "R6 code" : (ecode == 1 ? "R3 code" : "R4 code"),
          32'(rsp_code), 32'(ecode));
    check("R10/R6 paddr", 32'(rsp_paddr), 32'(epa));
    check("R3/R4 fault flag", 32'(rsp_fault), 32'(ecode != 0));
    check("R5 memory reads", 32'(mem_hits - hits0), (ecode == 0) ? 32'd1 : 32'd0);
    if (ecode == 0) check("R5 entry address", 32'(last_addr), 32'(eaddr));
    pa0 = rsp_paddr;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R8 held valid", 32'(rsp_valid), 32'd1);
      check("R8 held paddr", 32'(rsp_paddr), 32'(pa0));
      check("R7 no accept while pending", 32'(req_ready), 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED1));
    for (int i = 0; i < 16; i++) begin sh_v[i] = 0; sh_p[i] = '0; sh_l[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 req_ready", 32'(req_ready), 32'd1);
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
    xlat(24'h5_00_123, 0);                 // R1 segments invalid, R3
    load_seg(3, 1'b1, 16'h2000, 9'h014);
    xlat(24'h3_13_ABC, 0);                 // R6 last page in range
    xlat(24'h3_14_ABC, 0);                 // R4 first page out of range
    xlat(24'h3_FF_001, 0);                 // R4
    load_seg(7, 1'b1, 16'hFFF0, 9'd256);
    xlat(24'h7_FF_FFF, 0);                 // R5 address wrap, full length
    load_seg(2, 1'b1, 16'h1234, 9'd0);
    xlat(24'h2_00_000, 0);                 // R4 zero length
    xlat(24'h3_00_777, 5);                 // R8 back-pressure
    load_seg(3, 1'b0, 16'h2000, 9'h014);
    xlat(24'h3_00_777, 0);                 // R9 invalidation, R3
    for (int i = 0; i < 16; i++)
      load_seg(i, 1'($urandom % 4 != 0), 16'($urandom), 9'($urandom % 257));
    for (int n = 0; n < 300; n++) begin
      logic [23:0] va = 24'($urandom);
      int s = int'(va[23:20]);
      if (n % 3 == 0 && sh_l[s] != 0) va[19:12] = 8'(sh_l[s] - 9'd1 + 9'($urandom % 2));
      xlat(va, int'($urandom % 3));
      if (n % 50 == 49)
        load_seg(int'($urandom % 16), 1'b1, 16'($urandom), 9'($urandom % 257)); // R9
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule